// File: doc/BRIEF.md
# I2C Bus Hang Recovery Controller

This block frees an I2C bus that a target device has left stuck, with SDA held low after a transaction was cut short. It sits beside an ordinary I2C master and owns the open-drain drive of SCL and SDA only while a recovery runs. It never drives a line high. It either pulls a line low or lets it go, and an external pull-up returns a released line to high.

A recovery starts on a request pulse. It also starts by itself when SDA has been low with SCL high for a set number of idle clocks.

The block clocks SCL at a programmable half-period. It respects clock stretching by a target and watches SDA during every SCL high phase. As soon as SDA is seen high, it stops pulsing and puts a STOP condition on the bus. If SDA is still low after nine pulses, or if a target holds SCL low for too long, the recovery ends with a failure. At the end, a one-cycle completion pulse is given, and a failure flag tells the two outcomes apart.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, both drive-low outputs are 0 (lines released) and `busy`, `done` and `fail` are 0.
- R2: A request accepted while idle raises `busy` on the next clock. It then drives SCL low for exactly `half_div` clocks. A `half_div` of 0 counts as 1. The value is captured when the request is accepted.
- R3: After releasing SCL, the block counts no high time until `scl_in` reads 1. A target stretching SCL for less than the timeout does not make the recovery fail.
- R4: Each high phase lasts `half_div` clocks after SCL is seen high. If `sda_in` reads 1 during a high phase, pulsing ends at once. With a target that releases SDA on the K-th SCL falling edge caused by the block (K of 0 or 1 meaning the first), SCL rises max(K,1) times before the STOP.
- R5: The STOP first holds SCL low with SDA released for one half-period. It then drives SDA low with SCL still low for one half-period. Next it releases SCL and waits for it to read high. After one more half-period it releases SDA. A successful recovery therefore adds exactly one SCL rise and exactly one SDA rise while SCL is high.
- R6: If SDA is still low at the end of the ninth high phase, `fail` is set and the run ends with both lines released. SCL then shows exactly 9 rises.
- R7: If SCL stays low for STRETCH_HALVES half-periods while the block has it released, `fail` is set and the run ends.
- R8: `done` is a single-cycle pulse, and `busy` is 1 up to and including that cycle and 0 after it. `fail` is valid from the `done` cycle and keeps its value until the next accepted request.
- R9: A request arriving while `busy` is 1 is ignored. It neither restarts the sequence nor queues a second run.
- R10: While idle, `sda_in` low together with `scl_in` high for HANG_CLKS consecutive clocks starts a recovery without a request. A shorter stretch of that condition does not start one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Recovery request pulse |
| half_div | input | DIV_W | SCL half-period in system clocks |
| scl_in | input | 1 | Synchronized SCL line level |
| sda_in | input | 1 | Synchronized SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle end-of-recovery pulse |
| fail | output | 1 | Last recovery failed |

## Verification
A wrong internal state in this block shows on the bus within one half-period. If the pulse count is off, the number of SCL rises before the STOP changes. If the phase timer is off, the measured SCL low time no longer equals the divider value. If the state order in the STOP is off, SDA moves while SCL is high at the wrong moment, or the STOP rise is missing. Timeout and hang-detect counters that are off show as a wrong `fail` value at `done`, or as a recovery that starts too early or not at all.

// File: rtl/i2c_bus_unstick.sv
`timescale 1ns/1ps
module i2c_bus_unstick #(
  parameter int DIV_W          = 16,
  parameter int PULSES         = 9,
  parameter int STRETCH_HALVES = 8,
  parameter int HANG_CLKS      = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [DIV_W-1:0] half_div,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_drive_low,
  output logic             sda_drive_low,
  output logic             busy,
  output logic             done,
  output logic             fail
);
  localparam int PW = $clog2(PULSES + 1);
  localparam int SW = $clog2(STRETCH_HALVES + 1);
  localparam int HW = $clog2(HANG_CLKS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_LOW, S_RISE, S_HIGH, S_SLOW, S_SDAL, S_SRISE, S_SHOLD, S_END
  } st_t;

  st_t              st;
  logic [DIV_W-1:0] div_q, tmr;
  logic [PW-1:0]    pulses;
  logic [SW-1:0]    halves;
  logic [HW-1:0]    hang_cnt;
  logic             fail_q;

  wire tmr_end  = (tmr == div_q - 1'b1);
  wire hang_on  = !sda_in && scl_in;
  wire hang_hit = hang_on && (hang_cnt == HW'(HANG_CLKS - 1));
  wire last_p   = (pulses == PW'(PULSES - 1));
  wire last_h   = (halves == SW'(STRETCH_HALVES - 1));

  assign scl_drive_low = (st == S_LOW) || (st == S_SLOW) || (st == S_SDAL);
  assign sda_drive_low = (st == S_SDAL) || (st == S_SRISE) || (st == S_SHOLD);
  assign busy          = (st != S_IDLE);
  assign done          = (st == S_END);
  assign fail          = fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      div_q    <= '0;
      tmr      <= '0;
      pulses   <= '0;
      halves   <= '0;
      hang_cnt <= '0;
      fail_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          tmr    <= '0;
          pulses <= '0;
          halves <= '0;
          if (req || hang_hit) begin
            st       <= S_LOW;
            div_q    <= (half_div == '0) ? DIV_W'(1) : half_div;
            fail_q   <= 1'b0;
            hang_cnt <= '0;
          end else begin
            hang_cnt <= hang_on ? hang_cnt + 1'b1 : '0;
          end
        end
        S_LOW: begin
          if (tmr_end) begin
            tmr    <= '0;
            halves <= '0;
            st     <= S_RISE;
          end else tmr <= tmr + 1'b1;
        end
        S_RISE, S_SRISE: begin
          if (scl_in) begin
            tmr <= '0;
            st  <= (st == S_RISE) ? S_HIGH : S_SHOLD;
          end else if (tmr_end) begin
            tmr <= '0;
            if (last_h) begin
              fail_q <= 1'b1;
              st     <= S_END;
            end else halves <= halves + 1'b1;
          end else tmr <= tmr + 1'b1;
        end
        S_HIGH: begin
          if (sda_in) begin
            tmr <= '0;
            st  <= S_SLOW;
          end else if (tmr_end) begin
            tmr <= '0;
            if (last_p) begin
              fail_q <= 1'b1;
              st     <= S_END;
            end else begin
              pulses <= pulses + 1'b1;
              st     <= S_LOW;
            end
          end else tmr <= tmr + 1'b1;
        end
        S_SLOW: begin
          if (tmr_end) begin
            tmr <= '0;
            st  <= S_SDAL;
          end else tmr <= tmr + 1'b1;
        end
        S_SDAL: begin
          if (tmr_end) begin
            tmr    <= '0;
            halves <= '0;
            st     <= S_SRISE;
          end else tmr <= tmr + 1'b1;
        end
        S_SHOLD: begin
          if (tmr_end) begin
            tmr <= '0;
            st  <= S_END;
          end else tmr <= tmr + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req && !busy |=> busy);
  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done);
  p_sda_grab_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> scl_drive_low);
  p_stop_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_low) && !fail |-> scl_in && !scl_drive_low);
  p_fail_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done && !scl_drive_low);
  p_pulse_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= PW'(PULSES - 1));
endmodule

// File: tb/test_i2c_bus_unstick.sv
`timescale 1ns/1ps
module test_i2c_bus_unstick;
  localparam int DW = 16;
  logic clk = 0, rst_n = 0, req = 0;
  logic [DW-1:0] half_div = 16'd4;
  logic tgt_sda_hold = 0, tgt_scl_hold = 0;
  logic scl_drive_low, sda_drive_low, busy, done, fail;
  wire scl_line = !(scl_drive_low || tgt_scl_hold);
  wire sda_line = !(sda_drive_low || tgt_sda_hold);

  int checks = 0, errs = 0;
  int falls = 0, rises = 0, stops = 0, done_cnt = 0;
  int k_rel = 0, stretch_req = 0;
  time t_fall = 0, t_rise = 0;

  i2c_bus_unstick #(.DIV_W(DW), .PULSES(9), .STRETCH_HALVES(4), .HANG_CLKS(200)) i_i2c_bus_unstick (
    .clk(clk), .rst_n(rst_n), .req(req), .half_div(half_div),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .busy(busy), .done(done), .fail(fail));

  always #5 clk = ~clk;

  always begin
    @(negedge scl_line);
    falls++;
    if (falls == 1) t_fall = $time;
    if (k_rel != 0 && falls >= k_rel) tgt_sda_hold = 0;
    if (stretch_req != 0 && falls == 1) begin
      tgt_scl_hold = 1;
      if (stretch_req > 0) begin
        repeat (stretch_req) @(posedge clk);
        tgt_scl_hold = 0;
      end
    end
  end
  always @(posedge scl_line) begin
    rises++;
    if (rises == 1) t_rise = $time;
  end
  always @(posedge sda_line) if (scl_line) stops++;
  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input int div, input int k, input int str, input logic extra_req);
    @(negedge clk);
    half_div = DW'(div);
    falls = 0; rises = 0; stops = 0; done_cnt = 0;
    k_rel = k; stretch_req = str;
    tgt_sda_hold = 1;
    if (k == 0) tgt_sda_hold = 0;
    @(negedge clk);
    req = 1;
    @(negedge clk);
    req = 0;
    chk("R2 busy after request", busy, 1);
    if (extra_req) begin
      repeat (7) @(negedge clk);
      req = 1; @(negedge clk); req = 0;
      repeat (5) @(negedge clk);
      req = 1; @(negedge clk); req = 0;
    end
    for (int i = 0; i < 3000 && done_cnt == 0; i++) @(negedge clk);
    chk("R8 single done", done_cnt, 1);
  endtask

  task automatic finish_case();
    @(negedge clk);
    chk("R8 busy low after done", busy, 0);
    stretch_req = 0;
    tgt_scl_hold = 0;
    tgt_sda_hold = 0;
    k_rel = 0;
    repeat (3) @(negedge clk);
  endtask

  localparam logic [24:0] VEC [0:5] = '{
    {8'd4, 8'd0,  8'd2,  1'b0},
    {8'd4, 8'd3,  8'd4,  1'b0},
    {8'd6, 8'd9,  8'd10, 1'b0},
    {8'd5, 8'd10, 8'd9,  1'b1},
    {8'd4, 8'd20, 8'd9,  1'b1},
    {8'd7, 8'd1,  8'd2,  1'b0}
  };

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 scl released", scl_drive_low, 0);
    chk("R1 sda released", sda_drive_low, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 fail", fail, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    foreach (VEC[n]) begin
      int div, k, er;
      logic ef;
      div = int'(VEC[n][24:17]);
      k   = int'(VEC[n][16:9]);
      er  = int'(VEC[n][8:1]);
      ef  = VEC[n][0];
      run_case(div, k, 0, 1'b0);
      chk(ef ? "R6 scl rises on fail" : "R4 scl rises before and at stop", rises, er);
      chk(ef ? "R6 fail flag" : "R8 fail flag", fail, int'(ef));
      chk("R5 stop events", stops, ef ? 0 : 1);
      chk("R2 low phase clocks", int'((t_rise - t_fall) / 10), div);
      chk("R6 lines released at end", int'({scl_drive_low, sda_drive_low}), 0);
      finish_case();
    end

    run_case(0, 2, 0, 1'b0);
    chk("R2 zero divider counts as one", int'((t_rise - t_fall) / 10), 1);
    chk("R4 zero divider rises", rises, 3);
    finish_case();

    run_case(4, 2, 8, 1'b0);
    chk("R3 short stretch succeeds", fail, 0);
    chk("R3 stretch rises", rises, 3);
    finish_case();

    run_case(4, 20, -1, 1'b0);
    chk("R7 stretch timeout fails", fail, 1);
    chk("R7 no rise while held", rises, 0);
    finish_case();
    chk("R8 fail held until next request", fail, 1);

    run_case(4, 3, 0, 1'b1);
    chk("R9 rises unaffected by busy request", rises, 4);
    chk("R9 fail", fail, 0);
    chk("R8 fail cleared by new request", fail, 0);
    finish_case();
    repeat (5) @(negedge clk);
    chk("R9 no queued run", busy, 0);

    falls = 0; rises = 0; stops = 0; done_cnt = 0;
    half_div = 16'd4;
    k_rel = 2;
    tgt_sda_hold = 1;
    repeat (150) @(negedge clk);
    chk("R10 no early auto start", busy, 0);
    repeat (60) @(negedge clk);
    chk("R10 auto start on hang", busy, 1);
    for (int i = 0; i < 3000 && done_cnt == 0; i++) @(negedge clk);
    chk("R10 auto recovery rises", rises, 3);
    chk("R10 auto recovery stop", stops, 1);
    finish_case();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule